// File: doc/BRIEF.md
# 17x17 Multiply-Accumulate Unit

This block multiplies two 16-bit operands and folds the product into a 40-bit accumulator value in one clock cycle. Each operand has a flag that says whether it is signed. The flag decides how the operand grows to 17 bits: sign extension when the flag is set, zero extension when it is clear. Because the multiplier is 17 by 17 and two's-complement, signed, unsigned and mixed products all use the same array. A 16-bit holding register, called T, can stand in for the first operand. The host loads T one cycle and names it as the source on later cycles.

A per-operation mode chooses several things:
- accumulate or subtract;
- fractional doubling of the product;
- rounding to a 16-bit boundary;
- clamping to the 32-bit signed range.

The unit flags a result outside that range. It also flags a result that is all zeros. The result and both flags are registered. They change only on cycles where the enable is high.

Top module: `mac17_unit`

## Requirements
- R1: An operand whose signed flag is 1 is sign-extended from bit 15 to 17 bits, and one whose flag is 0 is zero-extended. The product is the exact two's-complement product of the two 17-bit values.
- R2: With `sub`=0, `result` equals `acc_in` (taken as 40-bit signed) plus the product. It appears after the rising edge at which `en`=1 sampled the inputs.
- R3: With `sub`=1, `result` equals `acc_in` minus the product.
- R4: With `frac`=1, the product is doubled (shifted left by one) before it is added or subtracted.
- R5: When `t_wr`=1 at a rising edge, T takes `t_din`. When `use_t`=1, T replaces `x_din` as the first operand, and `x_sgn` still gives its signedness.
- R6: With `rnd`=1, 0x8000 is added to the sum and then bits 15..0 are cleared.
- R7: `ovf`=1 when the rounded value lies outside the range -2^31 to 2^31-1. This holds whatever `sat` is.
- R8: With `sat`=1 and an overflow, `result` is 0x007FFFFFFF for a positive value and 0xFF80000000 for a negative one.
- R9: With `sat`=0, `result` is the low 40 bits of the rounded value, wrapping modulo 2^40.
- R10: `zero`=1 exactly when all 40 bits of `result` are 0.
- R11: While `en`=0, `result`, `zero` and `ovf` keep their values.
- R12: Reset gives `result`=0, `zero`=1, `ovf`=0 and T=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Capture a new result at this edge |
| t_wr | input | 1 | Load T from t_din |
| t_din | input | 16 | Value for T |
| use_t | input | 1 | Use T as the first operand |
| x_din | input | 16 | First operand |
| x_sgn | input | 1 | First operand is signed |
| y_din | input | 16 | Second operand |
| y_sgn | input | 1 | Second operand is signed |
| acc_in | input | 40 | Accumulator value, two's complement |
| sub | input | 1 | 1: accumulator minus product |
| frac | input | 1 | Double the product |
| rnd | input | 1 | Round to bit 16 |
| sat | input | 1 | Clamp on overflow |
| result | output | 40 | Registered result |
| zero | output | 1 | Result is all zeros |
| ovf | output | 1 | Rounded value exceeds 32-bit signed range |

## Verification
`result`, `zero` and `ovf` are due one edge after the enabled edge that sampled the operands. The bench drives each operation on a falling edge and compares all three outputs on the next falling edge, halfway between edges. A T load takes effect at its own edge, so the bench loads T one full cycle before any operation that uses it. The hold checks drop `en` and change every input, then read the outputs again one falling edge later.

// File: rtl/mac_pkg.sv
package mac_pkg;

  typedef enum logic {
    MAC_ADD = 1'b0,
    MAC_SUB = 1'b1
  } mac_op_e;

  typedef struct packed {
    mac_op_e op;
    logic    dbl;
    logic    rnd;
    logic    clamp;
  } mac_mode_t;

endpackage

// File: rtl/mac_mul.sv
module mac_mul #(
  parameter int OP_W = 16
) (
  input  logic [OP_W-1:0]       opa,
  input  logic                  opa_sgn,
  input  logic [OP_W-1:0]       opb,
  input  logic                  opb_sgn,
  input  logic                  dbl,
  output logic [2*(OP_W+1):0]   prod_o
);
  localparam int MUL_W  = OP_W + 1;
  localparam int PROD_W = 2 * MUL_W;

  logic [1:0][OP_W-1:0]  raw;
  logic [1:0]            sgn;
  logic [1:0][MUL_W-1:0] ext;
  logic signed [PROD_W-1:0] prod;

  assign raw = {opb, opa};
  assign sgn = {opb_sgn, opa_sgn};

  // widen each operand to 17 bits: sign or zero fill
  for (genvar i = 0; i < 2; i++) begin : g_ext
    assign ext[i] = {sgn[i] & raw[i][OP_W-1], raw[i]};
  end

  assign prod = $signed(ext[0]) * $signed(ext[1]);

  always_comb begin
    if (dbl) prod_o = {prod, 1'b0};
    else     prod_o = {prod[PROD_W-1], prod};
  end

endmodule

// File: rtl/mac_sum.sv
module mac_sum #(
  parameter int ACC_W   = 40,
  parameter int PW      = 35,
  parameter int RND_BIT = 15
) (
  input  logic [ACC_W-1:0]  acc,
  input  logic [PW-1:0]     prod,
  input  logic              sub,
  input  logic              rnd,
  output logic [ACC_W+1:0]  sum_o
);
  localparam int EXT_W = ACC_W + 2;
  localparam logic [EXT_W-1:0] HALF = {{(EXT_W-1){1'b0}}, 1'b1} << RND_BIT;

  logic [EXT_W-1:0] acc_x;
  logic [EXT_W-1:0] prod_x;
  logic [EXT_W-1:0] raw;
  logic [EXT_W-1:0] bumped;

  assign acc_x  = {{2{acc[ACC_W-1]}}, acc};
  assign prod_x = {{(EXT_W-PW){prod[PW-1]}}, prod};

  always_comb begin
    if (sub) raw = acc_x - prod_x;
    else     raw = acc_x + prod_x;
  end

  assign bumped = raw + HALF;

  always_comb begin
    if (rnd) sum_o = {bumped[EXT_W-1:RND_BIT+1], {(RND_BIT+1){1'b0}}};
    else     sum_o = raw;
  end

endmodule

// File: rtl/mac_clamp.sv
module mac_clamp #(
  parameter int ACC_W = 40,
  parameter int SAT_W = 32
) (
  input  logic [ACC_W+1:0] val,
  input  logic             sat,
  output logic [ACC_W-1:0] res_o,
  output logic             zero_o,
  output logic             ovf_o
);
  localparam int EXT_W = ACC_W + 2;
  localparam int TOP_W = EXT_W - SAT_W + 1;
  localparam logic [ACC_W-1:0] POS_LIM = {{(ACC_W-SAT_W+1){1'b0}}, {(SAT_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] NEG_LIM = {{(ACC_W-SAT_W+1){1'b1}}, {(SAT_W-1){1'b0}}};

  logic [TOP_W-1:0] upper;

  assign upper = val[EXT_W-1:SAT_W-1];
  assign ovf_o = ~((&upper) | (~|upper));

  always_comb begin
    if (sat && ovf_o) res_o = val[EXT_W-1] ? NEG_LIM : POS_LIM;
    else              res_o = val[ACC_W-1:0];
  end

  assign zero_o = ~|res_o;

endmodule

// File: rtl/mac17_unit.sv
module mac17_unit #(
  parameter int OP_W    = 16,
  parameter int ACC_W   = 40,
  parameter int GUARD_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             t_wr,
  input  logic [OP_W-1:0]  t_din,
  input  logic             use_t,
  input  logic [OP_W-1:0]  x_din,
  input  logic             x_sgn,
  input  logic [OP_W-1:0]  y_din,
  input  logic             y_sgn,
  input  logic [ACC_W-1:0] acc_in,
  input  logic             sub,
  input  logic             frac,
  input  logic             rnd,
  input  logic             sat,
  output logic [ACC_W-1:0] result,
  output logic             zero,
  output logic             ovf
);
  import mac_pkg::*;

  localparam int MUL_W   = OP_W + 1;
  localparam int PW      = 2 * MUL_W + 1;
  localparam int EXT_W   = ACC_W + 2;
  localparam int SAT_W   = ACC_W - GUARD_W;
  localparam int RND_BIT = OP_W - 1;
  localparam logic [ACC_W-1:0] POS_LIM = {{(ACC_W-SAT_W+1){1'b0}}, {(SAT_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] NEG_LIM = {{(ACC_W-SAT_W+1){1'b1}}, {(SAT_W-1){1'b0}}};

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_ln;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ln = rst_sync[1];

  mac_mode_t mode;
  assign mode.op    = sub ? MAC_SUB : MAC_ADD;
  assign mode.dbl   = frac;
  assign mode.rnd   = rnd;
  assign mode.clamp = sat;

  // T holding register
  logic [OP_W-1:0] t_q, t_d;

  always_comb begin
    t_d = t_q;
    if (t_wr) t_d = t_din;
  end

  always_ff @(posedge clk or negedge rst_ln) begin
    if (!rst_ln) t_q <= '0;
    else         t_q <= t_d;
  end

  // R5
  t_load_chk: assert property (@(posedge clk) disable iff (!rst_ln)
    t_wr |=> (t_q == $past(t_din)));

  // datapath
  logic [OP_W-1:0]  opa;
  logic [PW-1:0]    prod;
  logic [EXT_W-1:0] sum;
  logic [ACC_W-1:0] res_c;
  logic             zero_c, ovf_c;

  assign opa = use_t ? t_q : x_din;

  mac_mul #(.OP_W(OP_W)) u_mul (
    .opa     (opa),
    .opa_sgn (x_sgn),
    .opb     (y_din),
    .opb_sgn (y_sgn),
    .dbl     (mode.dbl),
    .prod_o  (prod)
  );

  mac_sum #(.ACC_W(ACC_W), .PW(PW), .RND_BIT(RND_BIT)) u_sum (
    .acc   (acc_in),
    .prod  (prod),
    .sub   (mode.op == MAC_SUB),
    .rnd   (mode.rnd),
    .sum_o (sum)
  );

  mac_clamp #(.ACC_W(ACC_W), .SAT_W(SAT_W)) u_clamp (
    .val    (sum),
    .sat    (mode.clamp),
    .res_o  (res_c),
    .zero_o (zero_c),
    .ovf_o  (ovf_c)
  );

  // output register with clock enable
  logic [ACC_W-1:0] res_q, res_d;
  logic             zero_q, zero_d;
  logic             ovf_q, ovf_d;

  always_comb begin
    res_d  = res_q;
    zero_d = zero_q;
    ovf_d  = ovf_q;
    if (en) begin
      res_d  = res_c;
      zero_d = zero_c;
      ovf_d  = ovf_c;
    end
  end

  always_ff @(posedge clk or negedge rst_ln) begin
    if (!rst_ln) begin
      res_q  <= '0;
      zero_q <= 1'b1;
      ovf_q  <= 1'b0;
    end else begin
      res_q  <= res_d;
      zero_q <= zero_d;
      ovf_q  <= ovf_d;
    end
  end

  assign result = res_q;
  assign zero   = zero_q;
  assign ovf    = ovf_q;

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_ln)
    !en |=> ($stable(res_q) && $stable(zero_q) && $stable(ovf_q)));

  // R8
  sat_clamp_chk: assert property (@(posedge clk) disable iff (!rst_ln)
    (en && sat) |=> (!ovf_q || res_q == POS_LIM || res_q == NEG_LIM));

  // R8
  sat_range_chk: assert property (@(posedge clk) disable iff (!rst_ln)
    (en && sat) |=> ((&res_q[ACC_W-1:SAT_W-1]) || (~|res_q[ACC_W-1:SAT_W-1])));

  // R6
  rnd_low_chk: assert property (@(posedge clk) disable iff (!rst_ln)
    (en && rnd && !sat) |=> (res_q[RND_BIT:0] == '0));

  // R10
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_ln)
    zero_q == (res_q == '0));

endmodule

// File: tb/sim_mac17_unit.sv
`timescale 1ns/1ps
module sim_mac17_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, t_wr = 1'b0, use_t = 1'b0;
  logic [15:0] t_din = '0, x_din = '0, y_din = '0;
  logic        x_sgn = 1'b0, y_sgn = 1'b0;
  logic [39:0] acc_in = '0;
  logic        sub = 1'b0, frac = 1'b0, rnd = 1'b0, sat = 1'b0;
  logic [39:0] result;
  logic        zero, ovf;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [15:0] t_model = '0;
  logic [39:0] exp_res;
  logic        exp_zero, exp_ovf;

  always #4 clk = ~clk;

  mac17_unit u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .t_wr(t_wr), .t_din(t_din),
    .use_t(use_t), .x_din(x_din), .x_sgn(x_sgn), .y_din(y_din),
    .y_sgn(y_sgn), .acc_in(acc_in), .sub(sub), .frac(frac), .rnd(rnd),
    .sat(sat), .result(result), .zero(zero), .ovf(ovf)
  );

  task automatic chk(input string tag, input logic [39:0] got, input logic [39:0] want);
    checks++;
    if (got !== want) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, want);
    end
  endtask

  task automatic model(input logic [15:0] xa, input logic xs, input logic [15:0] yb,
                       input logic ys, input logic [39:0] acc, input logic sb,
                       input logic fr, input logic rd, input logic st);
    longint xv, yv, p, a, s, maxv, minv;
    maxv = (longint'(1) <<< 31) - 1;
    minv = -(longint'(1) <<< 31);
    xv = xs ? longint'($signed(xa)) : longint'({48'd0, xa});
    yv = ys ? longint'($signed(yb)) : longint'({48'd0, yb});
    p = xv * yv;
    if (fr) p = p * 2;
    a = {{24{acc[39]}}, acc};
    s = sb ? a - p : a + p;
    if (rd) s = (s + 32768) & ~64'hFFFF;
    exp_ovf = (s > maxv) || (s < minv);
    if (st && exp_ovf) exp_res = (s < 0) ? 40'hFF80000000 : 40'h007FFFFFFF;
    else               exp_res = s[39:0];
    exp_zero = (exp_res == 40'd0);
  endtask

  // drive at a falling edge, compare at the next falling edge
  task automatic op(input string tag, input logic [15:0] xa, input logic xs,
                    input logic [15:0] yb, input logic ys, input logic ut,
                    input logic [39:0] acc, input logic sb, input logic fr,
                    input logic rd, input logic st);
    en = 1'b1; x_din = xa; x_sgn = xs; y_din = yb; y_sgn = ys; use_t = ut;
    acc_in = acc; sub = sb; frac = fr; rnd = rd; sat = st;
    model(ut ? t_model : xa, xs, yb, ys, acc, sb, fr, rd, st);
    @(negedge clk);
    chk({tag, " result"}, result, exp_res);
    chk({tag, " zero R10"}, {39'd0, zero}, {39'd0, exp_zero});
    chk({tag, " ovf R7"}, {39'd0, ovf}, {39'd0, exp_ovf});
    en = 1'b0;
  endtask

  task automatic load_t(input logic [15:0] v);
    t_wr = 1'b1; t_din = v; t_model = v;
    @(negedge clk);
    t_wr = 1'b0;
  endtask

  task automatic hold_check();
    logic [39:0] r0;
    logic z0, o0;
    r0 = result; z0 = zero; o0 = ovf;
    en = 1'b0;
    x_din = 16'($urandom); y_din = 16'($urandom); acc_in = {8'($urandom), 32'($urandom)};
    sub = ~sub; frac = ~frac; rnd = ~rnd; sat = ~sat;
    @(negedge clk);
    chk("R11 hold result", result, r0);
    chk("R11 hold flags", {38'd0, zero, ovf}, {38'd0, z0, o0});
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R12 reset result", result, 40'd0);
    chk("R12 reset zero", {39'd0, zero}, 40'd1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R12 reset ovf", {39'd0, ovf}, 40'd0);

    // R12: T clears on reset; use it before any load
    op("R12 T reset", 16'hFFFF, 1'b1, 16'h0005, 1'b1, 1'b1, 40'd7, 0, 0, 0, 0);
    chk("R12 T zero value", result, 40'd7);

    // R1 extension cases
    op("R1 uu", 16'hFFFF, 0, 16'hFFFF, 0, 0, 40'd0, 0, 0, 0, 0);
    chk("R9 wrap unsigned", result, 40'h00FFFE0001);
    op("R1 ss", 16'hFFFF, 1, 16'hFFFF, 1, 0, 40'd0, 0, 0, 0, 0);
    chk("R1 signed", result, 40'd1);
    op("R1 su", 16'hFFFF, 1, 16'hFFFF, 0, 0, 40'd0, 0, 0, 0, 0);
    chk("R1 mixed", result, 40'hFFFFFF0001);
    // R2 / R3 / R10
    op("R2 add", 16'd2, 1, 16'd3, 1, 0, 40'd100, 0, 0, 0, 0);
    chk("R2 value", result, 40'd106);
    op("R3 sub to zero", 16'd2, 1, 16'd3, 1, 0, 40'd6, 1, 0, 0, 0);
    chk("R10 zero set", {39'd0, zero}, 40'd1);
    // R4 / R8 fractional -1 * -1
    op("R4 frac", 16'h8000, 1, 16'h8000, 1, 0, 40'd0, 0, 1, 0, 1);
    chk("R8 pos clamp", result, 40'h007FFFFFFF);
    op("R4 frac nosat", 16'h4000, 1, 16'h4000, 1, 0, 40'd0, 0, 1, 0, 0);
    chk("R4 doubled", result, 40'h0020000000);
    // R8 negative clamp
    op("R8 neg", 16'd1, 1, 16'd1, 1, 0, 40'hFF80000000, 1, 0, 0, 1);
    chk("R8 neg clamp", result, 40'hFF80000000);
    // R6 rounding boundaries
    op("R6 up", 16'd0, 0, 16'd0, 0, 0, 40'h0000008000, 0, 0, 1, 0);
    chk("R6 up value", result, 40'h0000010000);
    op("R6 down", 16'd0, 0, 16'd0, 0, 0, 40'h0000007FFF, 0, 0, 1, 0);
    chk("R6 down value", result, 40'd0);
    // R5 T operand
    load_t(16'h1234);
    op("R5 use T", 16'hBEEF, 0, 16'd2, 0, 1, 40'd0, 0, 0, 0, 0);
    chk("R5 T value", result, 40'h0000002468);
    hold_check();

    for (int i = 0; i < 400; i++) begin
      logic [39:0] acc;
      logic [3:0]  md;
      md = 4'($urandom);
      if (($urandom % 3) == 0) acc = {8'($urandom), 32'($urandom)};
      else                     acc = {{8{1'b0}}, 32'($urandom)} ^ {{9{md[0]}}, 31'd0};
      if ((i % 50) == 7) load_t(16'($urandom));
      op(md[3] ? "R8 rand" : (md[0] ? "R3 rand" : "R2 rand"),
         16'($urandom), 1'($urandom), 16'($urandom), 1'($urandom),
         1'(($urandom % 4) == 0), acc, md[0], md[1], md[2], md[3]);
      if ((i % 40) == 3) hold_check();
    end

    finish_up();
  end
endmodule